// File: doc/BRIEF.md
# Serial Port Register Block

This block is the byte-wide register front end of a serial port controller. A processor-style bus reads and writes its registers one byte per cycle. Behind it, received characters arrive on a valid/ready byte stream and transmitted characters leave on a one-cycle strobe. It holds three registers:

- a status register,
- an enable register,
- a frame-format register.

It also holds a 12-bit baud divisor split over two bytes and a one-entry receive holding slot. It drives three level interrupts: receive-complete, transmit-complete and data-empty.

Bit shifting, baud timing and parity are handled elsewhere. This block only keeps the register state coherent. Received characters are trimmed to the programmed character size. Status bits clear by read or by writing one. The interrupt levels are recomputed whenever the enable register is written. A power-down input holds the whole block in its reset state.

Top module: `sercom_regs`

## Requirements
- R1: After reset, status (offset 0) reads 0x20, enable (offset 1) reads 0x00, format (offset 2) reads 0x06, both divisor bytes (offsets 4 and 5) read 0x00, `rx_ready` is low and all three interrupts are low.
- R2: `rx_ready` is high only when the holding slot is empty and the receiver enable (enable bit 4) is set. An accepted byte fills the slot and sets status bit 7 (receive-complete). It also raises `irq_rxc` when enable bit 7 is set.
- R3: Reading offset 6 with the receiver enabled returns one of two values. If the slot is full, it returns the held byte ANDed with the character mask. If the slot is empty, it returns 0. The read then empties the slot, clears status bit 7 and lowers `irq_rxc`. With the receiver disabled, the read returns 0 and changes nothing.
- R4: The size code is {enable bit 2, format bit 2, format bit 1}.
  - Codes 0, 1, 2 and 3 select 5-, 6-, 7- and 8-bit masks.
  - Code 7 selects the 8-bit mask.
  - Codes 4, 5 and 6 keep the mask already in force.
  - The mask is updated on every write to offset 1 or offset 2, and is 8-bit after reset.
- R5: With the transmitter enable (enable bit 3) set, a write to offset 6 does the following:
  - It drives `tx_strobe` high for the next cycle, with `tx_data` equal to the written byte.
  - It sets status bits 6 (transmit-complete) and 5 (data-empty).
  - If enable bit 6 is set, it raises `irq_txc` and leaves status bit 6 clear instead.
  - If enable bit 5 is set, it raises `irq_dre`.
  
  With bit 3 clear, the write has no effect.
- R6: A status write loads bits 1:0 from the data and leaves bits 7 and 5 unchanged. Bit 6 always ends clear. If data bit 6 is 1, the write also lowers `irq_txc`.
- R7: An enable write keeps bit 1 unchanged (0 after reset) and loads all other bits. If the written bit 4 is 0, the holding slot is emptied. Each interrupt then equals its enable bit (7, 6, 5) ANDed with the matching status bit (7, 6, 5).
- R8: The format register and the low divisor byte take all 8 written bits. The high divisor byte keeps only the low 4 bits of the data.
- R9: While `pwr_off` is high, the block is held in its reset state. `bus_rdata` reads 0, writes are ignored, `rx_ready` is low and all outputs are low.
- R10: Offset 3 and offset 7 read as 0, and writes to them change no register.
- R11: `bus_rdata` is registered. It shows the addressed value in the cycle after `bus_rd` and holds it until the next read. A cycle with `bus_wr` high performs no read.
- R12: When a byte is accepted in the same cycle as an enabled read of offset 6, the read returns that byte, masked. The slot ends empty, status bit 7 ends clear and `irq_rxc` ends low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_off | input | 1 | Power-down; holds the block in reset while high |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | DATA_W | Received byte |
| rx_ready | output | 1 | Holding slot can accept a byte |
| tx_strobe | output | 1 | One-cycle pulse for an outgoing byte |
| tx_data | output | DATA_W | Outgoing byte |
| irq_rxc | output | 1 | Receive-complete interrupt level |
| irq_txc | output | 1 | Transmit-complete interrupt level |
| irq_dre | output | 1 | Data-empty interrupt level |

## Verification
The collision of interest is a byte arriving from the stream in the same clock edge as a processor read of the data offset. The slot, the status bit and the receive interrupt would then be both set and cleared at once. The bench provokes it by raising `rx_valid` and `bus_rd` at offset 6 in the same cycle while the slot is empty. The collision is judged as follows:
- the read must return the incoming byte masked;
- afterwards `rx_ready` must be high again and `irq_rxc` low;
- a status read must show bit 7 clear.

A second overlap is checked the same way: an enable write that disables the receiver while the slot is full. There, the flush must win, and a later enabled read must return 0.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
   // register offsets (low three address bits)
   localparam logic [2:0] OFS_STA  = 3'd0;
   localparam logic [2:0] OFS_CTL  = 3'd1;
   localparam logic [2:0] OFS_FMT  = 3'd2;
   localparam logic [2:0] OFS_DIVL = 3'd4;
   localparam logic [2:0] OFS_DIVH = 3'd5;
   localparam logic [2:0] OFS_DATA = 3'd6;

   // status register bits
   localparam int STA_RXC = 7;
   localparam int STA_TXC = 6;
   localparam int STA_DRE = 5;

   // enable register bits
   localparam int CTL_RXIE = 7;
   localparam int CTL_TXIE = 6;
   localparam int CTL_DEIE = 5;
   localparam int CTL_RXEN = 4;
   localparam int CTL_TXEN = 3;
   localparam int CTL_SZ2  = 2;

   // format register bits
   localparam int FMT_SZ1 = 2;
   localparam int FMT_SZ0 = 1;

   // writable masks and reset values
   localparam logic [7:0] STA_WMASK = 8'h43;
   localparam logic [7:0] CTL_WMASK = 8'hFD;
   localparam logic [7:0] STA_RST   = 8'h20;
   localparam logic [7:0] CTL_RST   = 8'h00;
   localparam logic [7:0] FMT_RST   = 8'h06;
endpackage

// File: rtl/sercom_szmask.sv
module sercom_szmask #(
   parameter int DATA_W   = 8,
   parameter int MIN_CHAR = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load_i,
   input  logic [2:0]        code_i,
   output logic [DATA_W-1:0] mask_o
);
   localparam int SEL_W = 2;
   localparam logic [SEL_W-1:0] SEL_MAX = '1;

   if (MIN_CHAR + 3 != DATA_W) begin : g_bad_geom
      $error("sercom_szmask: MIN_CHAR+3 must equal DATA_W");
   end

   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= SEL_MAX;
      end else if (clr) begin
         sel_q <= SEL_MAX;
      end else if (load_i) begin
         if (!code_i[2]) begin
            sel_q <= code_i[1:0];
         end else if (&code_i) begin
            sel_q <= SEL_MAX;
         end
      end
   end

   for (genvar g = 0; g < DATA_W; g++) begin : g_mask
      if (g < MIN_CHAR) begin : g_fixed
         assign mask_o[g] = 1'b1;
      end else begin : g_sel
         assign mask_o[g] = ({30'd0, sel_q} >= 32'(g - MIN_CHAR + 1));
      end
   end

   // R4
   wide_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && (&code_i) && !clr) |=> (&mask_o));

   // R4
   reserved_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && code_i[2] && !(&code_i) && !clr) |=> $stable(mask_o));
endmodule

// File: rtl/sercom_rxslot.sv
module sercom_rxslot #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en_i,
   input  logic              push_valid_i,
   input  logic [DATA_W-1:0] push_data_i,
   output logic              push_ready_o,
   output logic              accept_o,
   input  logic              take_i,
   input  logic              flush_i,
   output logic              have_o,
   output logic [DATA_W-1:0] data_o
);
   logic              have_q;
   logic [DATA_W-1:0] buf_q;

   assign push_ready_o = en_i & ~have_q & ~clr;
   assign accept_o     = push_valid_i & push_ready_o;
   assign have_o       = have_q | accept_o;
   assign data_o       = have_q ? buf_q : push_data_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_q <= 1'b0;
         buf_q  <= '0;
      end else begin
         if (accept_o) buf_q <= push_data_i;
         if (clr || flush_i || take_i) begin
            have_q <= 1'b0;
         end else if (accept_o) begin
            have_q <= 1'b1;
         end
      end
   end

   // R3
   take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> !have_q);

   // R2
   slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (have_q && !take_i && !flush_i && !clr) |=> (have_q && $stable(buf_q)));
endmodule

// File: rtl/sercom_regs.sv
module sercom_regs
   import sercom_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 3,
   parameter int DIVH_W   = 4,
   parameter int MIN_CHAR = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_off,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              tx_strobe,
   output logic [DATA_W-1:0] tx_data,
   output logic              irq_rxc,
   output logic              irq_txc,
   output logic              irq_dre
);
   localparam int DIVH_PAD = DATA_W - DIVH_W;

   if (DATA_W != 8) begin : g_bad_w
      $error("sercom_regs: DATA_W must be 8");
   end
   if (ADDR_W < 3) begin : g_bad_a
      $error("sercom_regs: ADDR_W must be at least 3");
   end
   if (DIVH_W < 1 || DIVH_W > DATA_W) begin : g_bad_d
      $error("sercom_regs: DIVH_W out of range");
   end

   // address decode: upper bits must be zero when present
   logic       upper_ok;
   logic [2:0] ofs;
   assign ofs = bus_addr[2:0];
   if (ADDR_W > 3) begin : g_upper
      assign upper_ok = ~|bus_addr[ADDR_W-1:3];
   end else begin : g_no_upper
      assign upper_ok = 1'b1;
   end

   logic [DATA_W-1:0] sta_q, ctl_q, fmt_q, divl_q;
   logic [DIVH_W-1:0] divh_q;
   logic [DATA_W-1:0] rdata_q, txd_q;
   logic              txs_q, irx_q, itx_q, ide_q;

   logic [DATA_W-1:0] n_sta, n_ctl, n_fmt, n_divl, n_rdata, n_txd;
   logic [DIVH_W-1:0] n_divh;
   logic              n_txs, n_irx, n_itx, n_ide;

   logic wr_go, rd_go, data_rd, flush, mask_load;
   logic [2:0] mask_code;
   logic [DATA_W-1:0] char_mask;
   logic slot_accept, slot_have;
   logic [DATA_W-1:0] slot_data;

   assign wr_go   = bus_wr & upper_ok & ~pwr_off;
   assign rd_go   = bus_rd & ~bus_wr & upper_ok & ~pwr_off;
   assign data_rd = rd_go & (ofs == OFS_DATA) & ctl_q[CTL_RXEN];
   assign flush   = wr_go & (ofs == OFS_CTL) & ~bus_wdata[CTL_RXEN];

   sercom_rxslot #(.DATA_W(DATA_W)) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr          (pwr_off),
      .en_i         (ctl_q[CTL_RXEN]),
      .push_valid_i (rx_valid),
      .push_data_i  (rx_data),
      .push_ready_o (rx_ready),
      .accept_o     (slot_accept),
      .take_i       (data_rd),
      .flush_i      (flush),
      .have_o       (slot_have),
      .data_o       (slot_data)
   );

   sercom_szmask #(.DATA_W(DATA_W), .MIN_CHAR(MIN_CHAR)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (pwr_off),
      .load_i (mask_load),
      .code_i (mask_code),
      .mask_o (char_mask)
   );

   always_comb begin
      n_sta   = sta_q;
      n_ctl   = ctl_q;
      n_fmt   = fmt_q;
      n_divl  = divl_q;
      n_divh  = divh_q;
      n_rdata = rdata_q;
      n_txd   = txd_q;
      n_txs   = 1'b0;
      n_irx   = irx_q;
      n_itx   = itx_q;
      n_ide   = ide_q;

      // byte arrival is applied before the bus access of the same cycle
      if (slot_accept) begin
         n_sta[STA_RXC] = 1'b1;
         if (ctl_q[CTL_RXIE]) n_irx = 1'b1;
      end

      if (rd_go) begin
         unique case (ofs)
            OFS_STA:  n_rdata = sta_q;
            OFS_CTL:  n_rdata = ctl_q;
            OFS_FMT:  n_rdata = fmt_q;
            OFS_DIVL: n_rdata = divl_q;
            OFS_DIVH: n_rdata = {{DIVH_PAD{1'b0}}, divh_q};
            OFS_DATA: begin
               if (ctl_q[CTL_RXEN]) begin
                  n_rdata        = slot_have ? (slot_data & char_mask) : '0;
                  n_sta[STA_RXC] = 1'b0;
                  n_irx          = 1'b0;
               end else begin
                  n_rdata = '0;
               end
            end
            default:  n_rdata = '0;
         endcase
      end

      if (wr_go) begin
         unique case (ofs)
            OFS_DATA: begin
               if (ctl_q[CTL_TXEN]) begin
                  n_txs          = 1'b1;
                  n_txd          = bus_wdata;
                  n_sta[STA_TXC] = 1'b1;
                  n_sta[STA_DRE] = 1'b1;
                  if (ctl_q[CTL_TXIE]) begin
                     n_itx          = 1'b1;
                     n_sta[STA_TXC] = 1'b0;
                  end
                  if (ctl_q[CTL_DEIE]) n_ide = 1'b1;
               end
            end
            OFS_STA: begin
               n_sta = (bus_wdata & STA_WMASK) | (n_sta & ~STA_WMASK);
               if (bus_wdata[STA_TXC]) begin
                  n_sta[STA_TXC] = 1'b0;
                  n_itx          = 1'b0;
               end
            end
            OFS_CTL: begin
               n_ctl = (bus_wdata & CTL_WMASK) | (ctl_q & ~CTL_WMASK);
               n_irx = n_ctl[CTL_RXIE] & n_sta[STA_RXC];
               n_itx = n_ctl[CTL_TXIE] & n_sta[STA_TXC];
               n_ide = n_ctl[CTL_DEIE] & n_sta[STA_DRE];
            end
            OFS_FMT:  n_fmt  = bus_wdata;
            OFS_DIVL: n_divl = bus_wdata;
            OFS_DIVH: n_divh = bus_wdata[DIVH_W-1:0];
            default:  ;
         endcase
      end

      if (pwr_off) begin
         n_sta   = STA_RST;
         n_ctl   = CTL_RST;
         n_fmt   = FMT_RST;
         n_divl  = '0;
         n_divh  = '0;
         n_rdata = '0;
         n_txd   = '0;
         n_txs   = 1'b0;
         n_irx   = 1'b0;
         n_itx   = 1'b0;
         n_ide   = 1'b0;
      end
   end

   assign mask_load = wr_go & ((ofs == OFS_CTL) | (ofs == OFS_FMT));
   assign mask_code = {n_ctl[CTL_SZ2], n_fmt[FMT_SZ1], n_fmt[FMT_SZ0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sta_q   <= STA_RST;
         ctl_q   <= CTL_RST;
         fmt_q   <= FMT_RST;
         divl_q  <= '0;
         divh_q  <= '0;
         rdata_q <= '0;
         txd_q   <= '0;
         txs_q   <= 1'b0;
         irx_q   <= 1'b0;
         itx_q   <= 1'b0;
         ide_q   <= 1'b0;
      end else begin
         sta_q   <= n_sta;
         ctl_q   <= n_ctl;
         fmt_q   <= n_fmt;
         divl_q  <= n_divl;
         divh_q  <= n_divh;
         rdata_q <= n_rdata;
         txd_q   <= n_txd;
         txs_q   <= n_txs;
         irx_q   <= n_irx;
         itx_q   <= n_itx;
         ide_q   <= n_ide;
      end
   end

   assign bus_rdata = rdata_q;
   assign tx_strobe = txs_q;
   assign tx_data   = txd_q;
   assign irq_rxc   = irx_q;
   assign irq_txc   = itx_q;
   assign irq_dre   = ide_q;

   // R2
   accept_sets_rxc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_accept && !data_rd && !pwr_off) |=> sta_q[STA_RXC]);

   // R5
   strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_strobe |-> $past(bus_wr && ofs == OFS_DATA && ctl_q[CTL_TXEN]));

   // R6
   sta_txc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && ofs == OFS_STA) |=> !sta_q[STA_TXC]);

   // R7
   ctl_dre_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && ofs == OFS_CTL) |=> (irq_dre == (ctl_q[CTL_DEIE] & sta_q[STA_DRE])));

   // R9
   pwr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_off |=> (bus_rdata == '0 && !irq_rxc && !irq_txc && !irq_dre && !tx_strobe));
endmodule

// File: tb/sercom_regs_tb.sv
module sercom_regs_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_off = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_ready;
   logic       tx_strobe;
   logic [7:0] tx_data;
   logic       irq_rxc, irq_txc, irq_dre;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   sercom_regs u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_off(pwr_off),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_strobe(tx_strobe), .tx_data(tx_data),
      .irq_rxc(irq_rxc), .irq_txc(irq_txc), .irq_dre(irq_dre)
   );

   // fields: [15:12] requirement, [11] write, [10:8] offset, [7:0] data or expected
   localparam int NVEC = 18;
   localparam logic [15:0] VEC [0:NVEC-1] = '{
      {4'd1,  1'b0, 3'd0, 8'h20},   // R1 status
      {4'd1,  1'b0, 3'd1, 8'h00},   // R1 enable
      {4'd1,  1'b0, 3'd2, 8'h06},   // R1 format
      {4'd1,  1'b0, 3'd4, 8'h00},   // R1 divisor low
      {4'd1,  1'b0, 3'd5, 8'h00},   // R1 divisor high
      {4'd8,  1'b1, 3'd5, 8'hFF},
      {4'd8,  1'b0, 3'd5, 8'h0F},   // R8 high divisor keeps 4 bits
      {4'd8,  1'b1, 3'd4, 8'hA5},
      {4'd8,  1'b0, 3'd4, 8'hA5},   // R8
      {4'd8,  1'b1, 3'd2, 8'h3C},
      {4'd8,  1'b0, 3'd2, 8'h3C},   // R8
      {4'd8,  1'b1, 3'd2, 8'h06},
      {4'd6,  1'b1, 3'd0, 8'hFF},
      {4'd6,  1'b0, 3'd0, 8'h23},   // R6 bits 1:0 loaded, bit 6 cleared
      {4'd6,  1'b1, 3'd0, 8'h00},
      {4'd10, 1'b1, 3'd3, 8'h55},
      {4'd10, 1'b0, 3'd3, 8'h00},   // R10
      {4'd10, 1'b0, 3'd7, 8'h00}    // R10
   };

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got %h exp %h", req, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      v = bus_rdata;
   endtask

   task automatic rx_push(input logic [7:0] d);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = d;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (all requirements) got timeout exp completion");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 outputs after reset
      chk("R1 irqs", {5'd0, irq_rxc, irq_txc, irq_dre}, 8'h00);
      chk("R1 rx_ready", {7'd0, rx_ready}, 8'h00);

      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][11]) begin
            wr_reg(VEC[i][10:8], VEC[i][7:0]);
         end else begin
            rd_reg(VEC[i][10:8], v);
            n_chk++;
            if (v !== VEC[i][7:0]) begin
               n_bad++;
               $display("FAIL R%0d vector %0d got %h exp %h", VEC[i][15:12], i, v, VEC[i][7:0]);
            end
         end
      end
      rd_reg(3'd0, v); chk("R6 status restore", v, 8'h20);

      // R7 read-only bit 1 of enable
      wr_reg(3'd1, 8'hFF);
      rd_reg(3'd1, v); chk("R7 enable bit1 read-only", v, 8'hFD);
      chk("R7 dre level", {7'd0, irq_dre}, 8'h01);
      wr_reg(3'd1, 8'h00);
      chk("R7 dre dropped", {7'd0, irq_dre}, 8'h00);

      // R2 receive acceptance
      chk("R2 not ready when disabled", {7'd0, rx_ready}, 8'h00);
      wr_reg(3'd1, 8'h90);
      chk("R2 ready", {7'd0, rx_ready}, 8'h01);
      rx_push(8'hC7);
      chk("R2 full not ready", {7'd0, rx_ready}, 8'h00);
      chk("R2 irq_rxc", {7'd0, irq_rxc}, 8'h01);
      rd_reg(3'd0, v); chk("R2 status rxc", v, 8'hA0);

      // R3 data read
      rd_reg(3'd6, v); chk("R3 data", v, 8'hC7);
      chk("R3 irq dropped", {7'd0, irq_rxc}, 8'h00);
      chk("R3 ready again", {7'd0, rx_ready}, 8'h01);
      rd_reg(3'd0, v); chk("R3 status cleared", v, 8'h20);
      rd_reg(3'd6, v); chk("R3 empty read", v, 8'h00);

      // R4 character-size masks
      wr_reg(3'd2, 8'h00); rx_push(8'hFF);
      rd_reg(3'd6, v); chk("R4 5-bit", v, 8'h1F);
      wr_reg(3'd2, 8'h02); rx_push(8'hFF);
      rd_reg(3'd6, v); chk("R4 6-bit", v, 8'h3F);
      wr_reg(3'd2, 8'h04); rx_push(8'hFF);
      rd_reg(3'd6, v); chk("R4 7-bit", v, 8'h7F);
      wr_reg(3'd1, 8'h94); rx_push(8'hFF);
      rd_reg(3'd6, v); chk("R4 reserved keeps 7-bit", v, 8'h7F);
      wr_reg(3'd2, 8'h06); rx_push(8'hFF);
      rd_reg(3'd6, v); chk("R4 nine as 8-bit", v, 8'hFF);
      wr_reg(3'd1, 8'h90);

      // R3 disabled read and R7 flush
      rx_push(8'h42);
      wr_reg(3'd1, 8'h80);
      chk("R7 irq_rxc recomputed", {7'd0, irq_rxc}, 8'h01);
      rd_reg(3'd6, v); chk("R3 disabled read", v, 8'h00);
      rd_reg(3'd0, v); chk("R3 disabled no side effect", v, 8'hA0);
      wr_reg(3'd1, 8'h90);
      rd_reg(3'd6, v); chk("R7 flushed", v, 8'h00);
      rd_reg(3'd0, v); chk("R7 status after read", v, 8'h20);

      // R12 arrival and data read in the same cycle
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'hE4; bus_rd = 1'b1; bus_addr = 3'd6;
      @(negedge clk);
      rx_valid = 1'b0; bus_rd = 1'b0;
      chk("R12 read returns arrival", bus_rdata, 8'hE4);
      chk("R12 irq low", {7'd0, irq_rxc}, 8'h00);
      chk("R12 slot empty", {7'd0, rx_ready}, 8'h01);
      rd_reg(3'd0, v); chk("R12 status", v, 8'h20);

      // R5 transmit
      wr_reg(3'd1, 8'h08);
      wr_reg(3'd6, 8'h5A);
      chk("R5 strobe", {7'd0, tx_strobe}, 8'h01);
      chk("R5 tx_data", tx_data, 8'h5A);
      chk("R5 irq_txc off", {7'd0, irq_txc}, 8'h00);
      rd_reg(3'd0, v); chk("R5 status txc+dre", v, 8'h60);
      chk("R5 strobe single", {7'd0, tx_strobe}, 8'h00);
      wr_reg(3'd0, 8'h40);
      rd_reg(3'd0, v); chk("R6 w1c txc", v, 8'h20);
      wr_reg(3'd1, 8'h68);
      chk("R7 dre on enable", {7'd0, irq_dre}, 8'h01);
      chk("R7 txc off on enable", {7'd0, irq_txc}, 8'h00);
      wr_reg(3'd6, 8'h81);
      chk("R5 strobe irq", {7'd0, tx_strobe}, 8'h01);
      chk("R5 irq_txc", {7'd0, irq_txc}, 8'h01);
      chk("R5 irq_dre", {7'd0, irq_dre}, 8'h01);
      rd_reg(3'd0, v); chk("R5 txc kept clear", v, 8'h20);
      wr_reg(3'd0, 8'h40);
      chk("R6 irq_txc dropped", {7'd0, irq_txc}, 8'h00);
      wr_reg(3'd1, 8'h00);
      chk("R7 dre off", {7'd0, irq_dre}, 8'h00);
      wr_reg(3'd6, 8'h77);
      chk("R5 disabled no strobe", {7'd0, tx_strobe}, 8'h00);
      chk("R5 disabled tx_data held", tx_data, 8'h81);

      // R11 registered read data
      rd_reg(3'd0, v);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 3'd2;
      #1 chk("R11 held before edge", bus_rdata, 8'h20);
      @(negedge clk);
      bus_rd = 1'b0;
      chk("R11 after edge", bus_rdata, 8'h06);
      @(negedge clk);
      bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h3E;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      chk("R11 write cycle no read", bus_rdata, 8'h06);

      // R9 power-down
      wr_reg(3'd1, 8'h90);
      @(negedge clk);
      pwr_off = 1'b1;
      @(negedge clk);
      chk("R9 rx_ready low", {7'd0, rx_ready}, 8'h00);
      rd_reg(3'd0, v); chk("R9 read zero", v, 8'h00);
      wr_reg(3'd4, 8'h33);
      @(negedge clk);
      pwr_off = 1'b0;
      rd_reg(3'd4, v); chk("R9 write ignored, divisor reset", v, 8'h00);
      rd_reg(3'd1, v); chk("R9 enable reset", v, 8'h00);
      rd_reg(3'd0, v); chk("R9 status reset", v, 8'h20);

      summary();
      $finish;
   end
endmodule